// File: doc/BRIEF.md
# Pulse Position Polarity Symbol Mapper

This block turns a serial stream of coded bits into impulse-radio symbols. Each symbol lasts one pulse repetition period, measured in fine clock ticks. At the start of every period the block takes a group of bits from a small internal bit store. The first bit of the group sets the sign of the pulse. The remaining bits choose one of Np equally spaced time slots inside the period. The block then raises a single-cycle pulse strobe at that slot, together with a polarity flag.

The period length and the number of positions (two or four) are run-time settings. A time-hopping offset can optionally be added to each pulse. Settings are checked for legality and take effect only at a period boundary, so a change in mid-period never distorts the symbol in flight. When too few bits are stored at a boundary, the period stays empty and an underrun indication covers it.

A symbol-start marker lets a downstream pulse generator or a checker align to the period grid.

Top module: `ppm_pol_mapper`

## Requirements
- R1: The first bit of a symbol, in arrival order, is the polarity bit. A 1 gives a negative pulse (`pulse_neg_o`=1 during the strobe) and a 0 gives a positive one. The next log2(Np) bits form the position index, most significant bit first.
- R2: With time hopping off, the strobe rises exactly index × floor(period/Np) ticks after the period's first tick. The first tick is tick 0, where `sym_mark_o` is high.
- R3: `cfg_np_log2`=1 selects two positions and 2 bits per symbol. `cfg_np_log2`=2 selects four positions and 3 bits per symbol.
- R4: Every period lasts exactly `cfg_period` clock cycles of the setting in force, and `sym_mark_o` is high on the first cycle of each period.
- R5: At most one strobe occurs per period. A strobe occurs only for a symbol whose bits were all stored at that period's boundary.
- R6: If fewer bits than one symbol needs are stored at a boundary, that period carries no strobe and `underrun_o` stays high through it. The stored bits are kept for a later symbol.
- R7: A setting change takes effect only at a period boundary. A change in mid-period leaves the running period's length unchanged.
- R8: A setting is rejected if `cfg_np_log2` is 0 or above the supported maximum, or if the position spacing would be zero. A rejected setting raises `cfg_err_o` for the following period and leaves the previous setting in force.
- R9: With `cfg_th_en`=1, `th_offset` (sampled at the boundary) is added to the slot offset. A sum beyond the period's last tick is clamped to tick period−1.
- R10: While reset is asserted, the block shows no strobe, no marker, no underrun and no setting error, and `in_ready` is high.
- R11: A bit is taken when `in_valid` and `in_ready` are both high. `in_ready` falls when the bit store holds twice the largest symbol size, and no accepted bit is ever lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coded bit offered |
| in_bit | input | 1 | Coded bit value |
| in_ready | output | 1 | Bit store can take a bit |
| cfg_period | input | PER_W | Period length in ticks |
| cfg_np_log2 | input | NL_W | log2 of the position count |
| cfg_th_en | input | 1 | Time-hopping offset enable |
| th_offset | input | TH_W | Time-hopping offset in ticks |
| pulse_o | output | 1 | Pulse strobe, one cycle |
| pulse_neg_o | output | 1 | Negative polarity, valid with the strobe |
| sym_mark_o | output | 1 | First tick of a period |
| underrun_o | output | 1 | Period left empty for lack of bits |
| cfg_err_o | output | 1 | Last presented setting was rejected |

## Verification
Every cycle, the assertions check several invariants:
- the tick counter stays inside the active period;
- a strobe never repeats within one period;
- the bit store never overfills and is never drained below a whole symbol;
- the active setting changes only at a boundary and is always legal.

Only the bench's scenarios can show that bits come back out in the right order and with the right meaning. It decodes each strobe's timing and sign back into bits for both position counts, with and without hopping, and compares them to what was sent. The scenarios also cover the clamped hopping cases, the period length before and after a mid-period change, and the retention of a partial symbol across an underrun.

// File: rtl/ppm_map_pkg.sv
package ppm_map_pkg;

  typedef enum logic {
    TMR_BOOT = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  // Tick distance between neighbouring positions.
  function automatic int unsigned pos_spacing(int unsigned period, int unsigned nl);
    return period >> nl;
  endfunction

  // A setting is usable when the position count is supported and slots do not collapse.
  function automatic bit cfg_legal(int unsigned period, int unsigned nl, int unsigned max_nl);
    return (nl >= 1) && (nl <= max_nl) && (pos_spacing(period, nl) != 0);
  endfunction

  // Position index from stored bits: bit 0 is polarity, bits 1..nl carry the index MSB first.
  function automatic int unsigned pos_from_bits(logic [15:0] bits, int unsigned nl);
    int unsigned pos;
    pos = 0;
    for (int unsigned k = 0; k < 7; k++) begin
      if (k < nl) pos = (pos << 1) | 32'(bits[k + 1]);
    end
    return pos;
  endfunction

  // Strobe tick inside the period, hop added and clamped to the last tick.
  function automatic int unsigned pulse_offset(int unsigned period, int unsigned nl,
                                               int unsigned pos, int unsigned hop);
    int unsigned raw;
    raw = pos * pos_spacing(period, nl) + hop;
    if (raw > period - 1) raw = period - 1;
    return raw;
  endfunction

endpackage

// File: rtl/ppm_bit_buffer.sv
module ppm_bit_buffer #(
  parameter int DEPTH = 6,
  parameter int POP_W = 2,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_bit,
  input  logic             pop,
  input  logic [POP_W-1:0] pop_n,
  output logic             ready,
  output logic [LVL_W-1:0] level,
  output logic [DEPTH-1:0] head
);

  logic [DEPTH-1:0] data_q, data_d;
  logic [LVL_W-1:0] lvl_after_pop, level_d;

  assign ready = (level < LVL_W'(DEPTH));
  assign head  = data_q;

  always_comb begin
    data_d        = pop ? (data_q >> pop_n) : data_q;
    lvl_after_pop = pop ? (level - LVL_W'(pop_n)) : level;
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (LVL_W'(i) == lvl_after_pop) data_d[i] = push_bit;
      end
    end
    level_d = lvl_after_pop + LVL_W'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      level  <= '0;
    end else begin
      data_q <= data_d;
      level  <= level_d;
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_pop_covered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level >= LVL_W'(pop_n));

  p_push_only_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == $past(level) + LVL_W'(1));

endmodule

// File: rtl/ppm_cfg_gate.sv
module ppm_cfg_gate
  import ppm_map_pkg::*;
#(
  parameter int PER_W      = 8,
  parameter int MAX_NL     = 2,
  parameter int NL_W       = $clog2(MAX_NL + 1),
  parameter int DEF_PERIOD = 16,
  parameter int DEF_NL     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PER_W-1:0] in_period,
  input  logic [NL_W-1:0]  in_nl,
  input  logic             in_th_en,
  output logic [PER_W-1:0] nxt_period,
  output logic [NL_W-1:0]  nxt_nl,
  output logic             nxt_th_en,
  output logic [PER_W-1:0] act_period,
  output logic             err_o
);

  logic [NL_W-1:0] act_nl;
  logic            act_th_en;
  logic            in_ok;

  assign in_ok      = cfg_legal(32'(in_period), 32'(in_nl), MAX_NL);
  assign nxt_period = in_ok ? in_period : act_period;
  assign nxt_nl     = in_ok ? in_nl     : act_nl;
  assign nxt_th_en  = in_ok ? in_th_en  : act_th_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period <= PER_W'(DEF_PERIOD);
      act_nl     <= NL_W'(DEF_NL);
      act_th_en  <= 1'b0;
      err_o      <= 1'b0;
    end else if (take) begin
      act_period <= nxt_period;
      act_nl     <= nxt_nl;
      act_th_en  <= nxt_th_en;
      err_o      <= !in_ok;
    end
  end

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(act_period) && $stable(act_nl) && $stable(act_th_en));

  p_act_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(32'(act_period), 32'(act_nl), MAX_NL));

  p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_ok) |=> $stable(act_period) && $stable(act_nl) && err_o);

endmodule

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer
  import ppm_map_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             sym_ok,
  input  logic [PER_W-1:0] sym_off,
  input  logic             sym_neg,
  output logic             boundary,
  output logic             pulse_o,
  output logic             pulse_neg_o,
  output logic             mark_o,
  output logic             underrun_o
);

  tmr_state_e       st;
  logic [PER_W-1:0] cnt;
  logic             live;
  logic [PER_W-1:0] off;
  logic             neg;

  assign boundary    = (st == TMR_BOOT) || (cnt == period - PER_W'(1));
  assign pulse_o     = live && (cnt == off);
  assign pulse_neg_o = pulse_o && neg;
  assign mark_o      = (st == TMR_RUN) && (cnt == '0);
  assign underrun_o  = (st == TMR_RUN) && !live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= TMR_BOOT;
      cnt  <= '0;
      live <= 1'b0;
      off  <= '0;
      neg  <= 1'b0;
    end else if (boundary) begin
      st   <= TMR_RUN;
      cnt  <= '0;
      live <= sym_ok;
      off  <= sym_off;
      neg  <= sym_neg;
    end else begin
      cnt  <= cnt + PER_W'(1);
    end
  end

  // Strobes seen since the last period start, for the one-per-period check.
  logic [1:0] pulses_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) pulses_seen <= '0;
    else if (mark_o) pulses_seen <= {1'b0, pulse_o};
    else if (pulse_o && pulses_seen != 2'd3) pulses_seen <= pulses_seen + 2'd1;
  end

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !mark_o) |-> pulses_seen == 2'd0);

  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TMR_RUN) |-> cnt < period);

  p_mark_after_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> mark_o);

  p_offset_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> off < period);

endmodule

// File: rtl/ppm_pol_mapper.sv
module ppm_pol_mapper
  import ppm_map_pkg::*;
#(
  parameter int PER_W      = 8,
  parameter int MAX_NL     = 2,
  parameter int NL_W       = $clog2(MAX_NL + 1),
  parameter int TH_W       = 4,
  parameter int DEF_PERIOD = 16,
  parameter int DEF_NL     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [NL_W-1:0]  cfg_np_log2,
  input  logic             cfg_th_en,
  input  logic [TH_W-1:0]  th_offset,
  output logic             pulse_o,
  output logic             pulse_neg_o,
  output logic             sym_mark_o,
  output logic             underrun_o,
  output logic             cfg_err_o
);

  localparam int BUF_D = 2 * (1 + MAX_NL);
  localparam int POP_W = $clog2(MAX_NL + 2);
  localparam int LVL_W = $clog2(BUF_D + 1);

  logic [BUF_D-1:0] head;
  logic [LVL_W-1:0] level;
  logic [POP_W-1:0] need;
  logic             boundary, sym_ok, pop;
  logic [PER_W-1:0] nxt_period, act_period, sym_off;
  logic [NL_W-1:0]  nxt_nl;
  logic             nxt_th_en;
  int unsigned      pos_val, hop;

  ppm_cfg_gate #(
    .PER_W(PER_W), .MAX_NL(MAX_NL), .NL_W(NL_W),
    .DEF_PERIOD(DEF_PERIOD), .DEF_NL(DEF_NL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(boundary),
    .in_period(cfg_period), .in_nl(cfg_np_log2), .in_th_en(cfg_th_en),
    .nxt_period(nxt_period), .nxt_nl(nxt_nl), .nxt_th_en(nxt_th_en),
    .act_period(act_period), .err_o(cfg_err_o)
  );

  ppm_bit_buffer #(.DEPTH(BUF_D), .POP_W(POP_W), .LVL_W(LVL_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && in_ready), .push_bit(in_bit),
    .pop(pop), .pop_n(need),
    .ready(in_ready), .level(level), .head(head)
  );

  // Symbol assembly under the setting that the coming boundary installs.
  assign need    = POP_W'(32'(nxt_nl) + 1);
  assign sym_ok  = level >= LVL_W'(need);
  assign pop     = boundary && sym_ok;
  assign pos_val = pos_from_bits(16'(head), 32'(nxt_nl));
  assign hop     = nxt_th_en ? 32'(th_offset) : 0;
  assign sym_off = PER_W'(pulse_offset(32'(nxt_period), 32'(nxt_nl), pos_val, hop));

  ppm_slot_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .period(act_period),
    .sym_ok(sym_ok), .sym_off(sym_off), .sym_neg(head[0]),
    .boundary(boundary), .pulse_o(pulse_o), .pulse_neg_o(pulse_neg_o),
    .mark_o(sym_mark_o), .underrun_o(underrun_o)
  );

  p_pop_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sym_mark_o && !underrun_o);

endmodule

// File: tb/ppm_pol_mapper_bench.sv
`timescale 1ns/1ps
module ppm_pol_mapper_bench;
  localparam int PER_W = 8, MAX_NL = 2, NL_W = 2, TH_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, pulse_o, pulse_neg_o, sym_mark_o, underrun_o, cfg_err_o;
  logic [PER_W-1:0] cfg_period = 8'd16;
  logic [NL_W-1:0]  cfg_np_log2 = 2'd1;
  logic             cfg_th_en = 1'b0;
  logic [TH_W-1:0]  th_offset = '0;

  ppm_pol_mapper #(.PER_W(PER_W), .MAX_NL(MAX_NL), .NL_W(NL_W), .TH_W(TH_W)) u_ppm_pol_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .cfg_period(cfg_period), .cfg_np_log2(cfg_np_log2), .cfg_th_en(cfg_th_en),
    .th_offset(th_offset), .pulse_o(pulse_o), .pulse_neg_o(pulse_neg_o),
    .sym_mark_o(sym_mark_o), .underrun_o(underrun_o), .cfg_err_o(cfg_err_o)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit q[$];
  int m_per = 16, m_nl = 1, m_th_en = 0, m_th = 0;
  bit mon_en = 0, saw_full = 0, done = 0;
  int cyc = 0, tick = 0, last_mark = 0, last_gap = 0, n_marks = 0, n_pulses = 0, last_ptick = 0;
  bit last_neg = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: decode each strobe back into bits and compare with the queue.
  task automatic decode();
    int need, pe, sp, rel;
    bit p;
    need = 1 + m_nl;
    if (q.size() < need) begin
      chk(0, "R5", q.size(), need);
      return;
    end
    p  = q.pop_front();
    pe = 0;
    for (int k = 0; k < m_nl; k++) pe = (pe << 1) | int'(q.pop_front());
    sp  = m_per >> m_nl;
    rel = tick - (m_th_en != 0 ? m_th : 0);
    chk(pulse_neg_o == p, "R1", int'(pulse_neg_o), int'(p));
    chk(rel >= 0 && rel % sp == 0, m_th_en != 0 ? "R9" : "R2", tick,
        pe * sp + (m_th_en != 0 ? m_th : 0));
    chk(rel / sp == pe, m_nl == 2 ? "R3" : "R2", rel / sp, pe);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sym_mark_o) begin
        tick = 0;
        last_gap = cyc - last_mark;
        last_mark = cyc;
        n_marks++;
      end else tick++;
      if (pulse_o) begin
        last_ptick = tick;
        last_neg = pulse_neg_o;
        if (mon_en) decode();
        n_pulses++;
      end
    end
  end

  task automatic wait_mark();
    int m0 = n_marks;
    wait (n_marks != m0);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    while (!in_ready) begin
      saw_full = 1;
      @(negedge clk);
    end
    q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_stream(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = (((i * 5 + seed) * 3) % 7) < 3;
      while (!in_ready) begin
        saw_full = 1;
        @(negedge clk);
      end
      q.push_back(in_bit);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_mode(int per, int nl, int the, int th);
    cfg_period = PER_W'(per); cfg_np_log2 = NL_W'(nl);
    cfg_th_en = the[0]; th_offset = TH_W'(th);
    m_per = per; m_nl = nl; m_th_en = the; m_th = th;
    wait_mark();
    wait_mark();
  endtask

  task automatic drain();
    wait (q.size() == 0);
    wait_mark();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired (t=%0t)", $time);
      report();
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs during reset
    chk(pulse_o == 0, "R10", int'(pulse_o), 0);
    chk(sym_mark_o == 0, "R10", int'(sym_mark_o), 0);
    chk(underrun_o == 0, "R10", int'(underrun_o), 0);
    chk(cfg_err_o == 0, "R10", int'(cfg_err_o), 0);
    chk(in_ready == 1, "R10", int'(in_ready), 1);
    mon_en = 1;
    @(negedge clk) rst_n = 1'b1;
    wait_mark();
    wait_mark();
    chk(underrun_o == 1, "R6", int'(underrun_o), 1);
    chk(last_gap == 16, "R4", last_gap, 16);

    // R6: a partial symbol waits in the store across empty periods
    send_bit(1'b1);
    wait_mark();
    wait_mark();
    chk(underrun_o == 1, "R6", int'(underrun_o), 1);
    send_stream(39, 1);
    drain();
    chk(q.size() == 0, "R1", q.size(), 0);

    // R3: four positions, 3 bits per symbol
    set_mode(12, 2, 0, 0);
    chk(last_gap == 12, "R4", last_gap, 12);
    send_stream(45, 2);
    drain();
    chk(q.size() == 0, "R3", q.size(), 0);

    // R11: long period backs the stream up
    set_mode(40, 1, 0, 0);
    saw_full = 0;
    send_stream(30, 3);
    chk(saw_full == 1, "R11", int'(saw_full), 1);
    drain();
    chk(q.size() == 0, "R11", q.size(), 0);

    // R9: hop added to every slot
    set_mode(16, 2, 1, 2);
    send_stream(24, 4);
    drain();

    // R9: clamp to last tick, period 10, spacing 5, hop 7
    set_mode(10, 1, 1, 7);
    mon_en = 0;
    p0 = n_pulses;
    send_bit(1'b0); send_bit(1'b1);
    wait (n_pulses != p0);
    chk(last_ptick == 9, "R9", last_ptick, 9);
    chk(last_neg == 0, "R1", int'(last_neg), 0);
    p0 = n_pulses;
    send_bit(1'b1); send_bit(1'b0);
    wait (n_pulses != p0);
    chk(last_ptick == 7, "R9", last_ptick, 7);
    chk(last_neg == 1, "R1", int'(last_neg), 1);
    q.delete();
    wait_mark();

    // R7: change in mid-period waits for the boundary
    set_mode(12, 1, 0, 0);
    wait_mark();
    repeat (3) @(negedge clk);
    cfg_period = 8'd20;
    wait_mark();
    chk(last_gap == 12, "R7", last_gap, 12);
    wait_mark();
    chk(last_gap == 20, "R7", last_gap, 20);

    // R8: illegal settings are refused
    cfg_np_log2 = 2'd0;
    wait_mark();
    chk(cfg_err_o == 1, "R8", int'(cfg_err_o), 1);
    wait_mark();
    chk(last_gap == 20, "R8", last_gap, 20);
    cfg_np_log2 = 2'd2; cfg_period = 8'd3;
    wait_mark();
    chk(cfg_err_o == 1, "R8", int'(cfg_err_o), 1);
    wait_mark();
    chk(last_gap == 20, "R8", last_gap, 20);
    cfg_np_log2 = 2'd1; cfg_period = 8'd16;
    wait_mark();
    chk(cfg_err_o == 0, "R8", int'(cfg_err_o), 0);
    wait_mark();
    chk(last_gap == 16, "R8", last_gap, 16);

    done = 1;
    report();
  end

endmodule